// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a physical address. It reads a four-level tree of translation tables that sits in ordinary memory. A start pulse loads the virtual address, and a root register gives the physical base of the top table. Before touching memory, the block checks that the upper address bits form a proper sign extension.

The walk then issues one 8-byte read per level over a request/response port, with only one read in flight at a time. Each read is indexed by a 9-bit slice of the virtual address. The walker takes the frame number out of each returned entry and uses it as the base of the next table.

When the walk ends, a one-cycle done pulse presents one of two results:
- the physical address and the permissions merged across all levels, or
- a fault code explaining why no translation was produced.

The block has no translation cache and does not support large pages. It never writes back into the tables.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `mem_req_valid_o` are all low.
- R2: If address bits 63:48 are not all equal to bit 47, the walk ends with `fault_o` = 2'b01 and no memory read is issued. In that case `paddr_o` and all permission outputs are 0.
- R3: The entry address at each level is the table base plus 8 times that level's index. The indices are taken from bits 47:39, 38:30, 29:21 and 20:12, in that order. The root base is `root_base_i` bits 51:12 followed by twelve zero bits.
- R4: Each later table base is the previous entry's bits 51:12 followed by twelve zero bits. Entry bits 63:52 and 11:3 do not affect any address.
- R5: On success (`fault_o` = 2'b00), `paddr_o` is the last entry's frame base (bits 51:12, shifted left by 12) ORed with virtual-address bits 11:0. A successful walk makes exactly four reads.
- R6: If bit 0 (present) of a returned entry is 0, the walk stops at once with `fault_o` = 2'b10. No further reads follow, and `paddr_o` and all permissions are 0.
- R7: On success, `perm_w_o` is the AND of entry bit 1 over all four levels, and `perm_u_o` is the AND of entry bit 2. `perm_nx_o` is the OR of entry bit 63.
- R8: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid with an unchanged address. A new request is raised only after the previous response has arrived.
- R9: A start pulse while `busy_o` is high is ignored: the running walk completes with its own result.
- R10: `done_o` is high for exactly one cycle per accepted start, and `busy_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a translation (accepted only when idle) |
| vaddr_i | input | 64 | Virtual address to translate |
| root_base_i | input | 64 | Physical base of the top table (bits 51:12 used) |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 64 | Physical address of the 8-byte entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Returned entry |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Walk in progress |
| paddr_o | output | 64 | Translated physical address |
| perm_w_o | output | 1 | Effective writable |
| perm_u_o | output | 1 | Effective user-accessible |
| perm_nx_o | output | 1 | Effective no-execute |
| fault_o | output | 2 | 00 none, 01 non-canonical, 10 not present |

## Verification
The assertions assume that memory returns exactly one response for each accepted request. That response is assumed to arrive no earlier than the cycle after the handshake, and `mem_rsp_valid_i` is assumed never to pulse when no read is pending. The bench memory model keeps to this. It answers one cycle after each accepted request and otherwise holds the response low. It may withhold ready on alternate cycles so that the stall path is exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE       = 2'b00,
      FLT_NONCANON   = 2'b01,
      FLT_NOTPRESENT = 2'b10
   } ptw_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_DONE
   } ptw_state_e;

   typedef struct packed {
      logic wr;
      logic usr;
      logic nx;
   } ptw_perm_t;

endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk #(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48
) (
   input  logic [ADDR_W-1:0] vaddr,
   output logic              canonical
);
   generate
      if (VA_BITS >= ADDR_W) begin : g_full
         assign canonical = 1'b1;
      end else begin : g_ext
         logic [ADDR_W-VA_BITS:0] upper;
         assign upper     = vaddr[ADDR_W-1:VA_BITS-1];
         assign canonical = (&upper) | ~(|upper);
      end
   endgenerate
endmodule

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
   parameter int LEVELS = 4,
   parameter int IDX_W  = 9,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [LEVELS*IDX_W-1:0] vpn,
   input  logic [LVL_W-1:0]        level,
   output logic [IDX_W-1:0]        index
);
   logic [IDX_W-1:0] slice [LEVELS];

   // level 0 is the top table and uses the most significant slice
   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_slice
         assign slice[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
      end
   endgenerate

   assign index = slice[level];
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
   import ptw_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int ENTRY_W = 64,
   parameter int PA_W    = 52,
   parameter int OFS_W   = 12,
   parameter int WR_BIT  = 1,
   parameter int USR_BIT = 2,
   parameter int NX_BIT  = 63
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic               present,
   output ptw_perm_t          perm,
   output logic [ADDR_W-1:0]  frame_base
);
   assign present    = entry[0];
   assign perm.wr    = entry[WR_BIT];
   assign perm.usr   = entry[USR_BIT];
   assign frame_base = {{(ADDR_W-PA_W){1'b0}}, entry[PA_W-1:OFS_W], {OFS_W{1'b0}}};

   generate
      if (NX_BIT < ENTRY_W && NX_BIT >= PA_W) begin : g_nx
         assign perm.nx = entry[NX_BIT];
      end else begin : g_no_nx
         assign perm.nx = 1'b0;
      end
   endgenerate

   logic unused_entry_bits;
   assign unused_entry_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFS_W-1:USR_BIT+1]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48,
   parameter int LEVELS  = 4,
   parameter int IDX_W   = 9,
   parameter int OFS_W   = 12,
   parameter int PA_W    = 52,
   parameter int ENTRY_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [63:0]       vaddr_i,
   input  logic [63:0]       root_base_i,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic [63:0]       mem_req_addr_o,
   input  logic              mem_rsp_valid_i,
   input  logic [63:0]       mem_rsp_data_i,
   output logic              done_o,
   output logic              busy_o,
   output logic [63:0]       paddr_o,
   output logic              perm_w_o,
   output logic              perm_u_o,
   output logic              perm_nx_o,
   output logic [1:0]        fault_o
);
   localparam int LVL_W    = $clog2(LEVELS);
   localparam int CNT_W    = LVL_W + 1;
   localparam int ENTRY_SH = $clog2(ENTRY_W / 8);
   localparam int VPN_W    = LEVELS * IDX_W;
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   generate
      if (ADDR_W != 64 || ENTRY_W != 64) begin : g_bad_width
         $error("ptw_walker: port widths are fixed at 64 bits");
      end
      if (VA_BITS != OFS_W + VPN_W) begin : g_bad_split
         $error("ptw_walker: VA_BITS must equal OFS_W + LEVELS*IDX_W");
      end
      if (LEVELS < 2 || (1 << LVL_W) != LEVELS) begin : g_bad_levels
         $error("ptw_walker: LEVELS must be a power of two, at least 2");
      end
      if (PA_W <= OFS_W || PA_W > ADDR_W) begin : g_bad_pa
         $error("ptw_walker: PA_W out of range");
      end
   endgenerate

   ptw_state_e             st_q;
   logic [LVL_W-1:0]       lvl_q;
   logic [ADDR_W-1:0]      base_q;
   logic [VA_BITS-1:0]     va_q;
   ptw_perm_t              perm_q;
   logic [ADDR_W-1:0]      paddr_q;
   ptw_fault_e             fault_q;

   logic                   canon;
   logic [IDX_W-1:0]       idx;
   logic                   ent_present;
   ptw_perm_t              ent_perm;
   logic [ADDR_W-1:0]      ent_frame;
   logic [ADDR_W-1:0]      root_frame;
   logic [ADDR_W-1:0]      entry_addr;

   ptw_canon_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_canon (
      .vaddr     (vaddr_i),
      .canonical (canon)
   );

   ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
      .vpn   (va_q[VA_BITS-1:OFS_W]),
      .level (lvl_q),
      .index (idx)
   );

   ptw_entry_dec #(
      .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFS_W(OFS_W)
   ) u_dec (
      .entry      (mem_rsp_data_i),
      .present    (ent_present),
      .perm       (ent_perm),
      .frame_base (ent_frame)
   );

   assign root_frame = {{(ADDR_W-PA_W){1'b0}}, root_base_i[PA_W-1:OFS_W], {OFS_W{1'b0}}};
   assign entry_addr = base_q + ({{(ADDR_W-IDX_W){1'b0}}, idx} << ENTRY_SH);

   logic unused_root_bits;
   assign unused_root_bits = ^{root_base_i[ADDR_W-1:PA_W], root_base_i[OFS_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         lvl_q   <= '0;
         base_q  <= '0;
         va_q    <= '0;
         perm_q  <= '0;
         paddr_q <= '0;
         fault_q <= FLT_NONE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  va_q    <= vaddr_i[VA_BITS-1:0];
                  lvl_q   <= '0;
                  base_q  <= root_frame;
                  paddr_q <= '0;
                  if (canon) begin
                     perm_q  <= '{wr: 1'b1, usr: 1'b1, nx: 1'b0};
                     fault_q <= FLT_NONE;
                     st_q    <= ST_REQ;
                  end else begin
                     perm_q  <= '0;
                     fault_q <= FLT_NONCANON;
                     st_q    <= ST_DONE;
                  end
               end
            end
            ST_REQ: begin
               if (mem_req_ready_i) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid_i) begin
                  if (!ent_present) begin
                     perm_q  <= '0;
                     fault_q <= FLT_NOTPRESENT;
                     st_q    <= ST_DONE;
                  end else begin
                     perm_q.wr  <= perm_q.wr  & ent_perm.wr;
                     perm_q.usr <= perm_q.usr & ent_perm.usr;
                     perm_q.nx  <= perm_q.nx  | ent_perm.nx;
                     base_q     <= ent_frame;
                     if (lvl_q == LAST_LVL) begin
                        paddr_q <= ent_frame | {{(ADDR_W-OFS_W){1'b0}}, va_q[OFS_W-1:0]};
                        st_q    <= ST_DONE;
                     end else begin
                        lvl_q <= lvl_q + 1'b1;
                        st_q  <= ST_REQ;
                     end
                  end
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid_o = (st_q == ST_REQ);
   assign mem_req_addr_o  = entry_addr;
   assign done_o          = (st_q == ST_DONE);
   assign busy_o          = (st_q != ST_IDLE);
   assign paddr_o         = paddr_q;
   assign perm_w_o        = perm_q.wr;
   assign perm_u_o        = perm_q.usr;
   assign perm_nx_o       = perm_q.nx;
   assign fault_o         = fault_q;

   // ---------------- assertion support: reads per walk ----------------
   logic [CNT_W-1:0] rd_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n) rd_cnt_q <= '0;
      else if (start_i && !busy_o) rd_cnt_q <= '0;
      else if (mem_req_valid_o && mem_req_ready_i) rd_cnt_q <= rd_cnt_q + 1'b1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> !done_o && !busy_o && !mem_req_valid_o);

   assert_noncanon_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == FLT_NONCANON |-> rd_cnt_q == '0);

   assert_full_walk_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == FLT_NONE |-> rd_cnt_q == CNT_W'(LEVELS));

   assert_absent_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid_i && !mem_rsp_data_i[0] && busy_o && !mem_req_valid_o
      |=> done_o && fault_o == FLT_NOTPRESENT);

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

   assert_no_req_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid_i |-> !mem_req_valid_o);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] vaddr_i = '0;
   logic [63:0] root_base_i = '0;
   logic        mem_req_valid_o;
   logic        mem_req_ready_i = 1'b1;
   logic [63:0] mem_req_addr_o;
   logic        mem_rsp_valid_i = 1'b0;
   logic [63:0] mem_rsp_data_i = '0;
   logic        done_o, busy_o;
   logic [63:0] paddr_o;
   logic        perm_w_o, perm_u_o, perm_nx_o;
   logic [1:0]  fault_o;

   always #2.5 clk = ~clk;

   ptw_walker dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
      .root_base_i(root_base_i), .mem_req_valid_o(mem_req_valid_o),
      .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
      .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
      .done_o(done_o), .busy_o(busy_o), .paddr_o(paddr_o), .perm_w_o(perm_w_o),
      .perm_u_o(perm_u_o), .perm_nx_o(perm_nx_o), .fault_o(fault_o)
   );

   int errors = 0;
   int checks = 0;

   logic [63:0] mem [logic [63:0]];
   logic [63:0] rd_addr [16];
   int          rd_cnt = 0;
   logic        pend = 1'b0;
   logic [63:0] pend_addr = '0;
   logic        stall_mode = 1'b0;
   logic        stall_tog = 1'b0;
   int          hold_err = 0;
   logic        prev_stalled = 1'b0;
   logic [63:0] prev_addr = '0;

   // memory model: answers one cycle after acceptance
   initial begin
      forever begin
         @(negedge clk);
         if (prev_stalled && (!mem_req_valid_o || mem_req_addr_o != prev_addr))
            hold_err++;
         mem_rsp_valid_i = 1'b0;
         if (pend) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
            pend = 1'b0;
         end
         stall_tog = ~stall_tog;
         mem_req_ready_i = stall_mode ? stall_tog : 1'b1;
         prev_stalled = mem_req_valid_o && !mem_req_ready_i;
         prev_addr    = mem_req_addr_o;
         if (mem_req_valid_o && mem_req_ready_i) begin
            pend = 1'b1;
            pend_addr = mem_req_addr_o;
            if (rd_cnt < 16) rd_addr[rd_cnt] = mem_req_addr_o;
            rd_cnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ent_addr(input logic [63:0] base, input logic [63:0] va, input int lvl);
      logic [8:0] ix;
      ix = va[47-9*lvl -: 9];
      return {12'h0, base[51:12], 12'h0} + {52'h0, ix, 3'b000};
   endfunction

   // builds a chain: tb[0]=root, tb[1..3]=lower tables, tb[4]=leaf frame
   task automatic build(input logic [63:0] va, input logic [63:0] tb [5], input logic [63:0] fl [4]);
      mem.delete();
      for (int l = 0; l < 4; l++)
         mem[ent_addr(tb[l], va, l)] = {12'h000, tb[l+1][51:12], 12'h000} | fl[l];
   endtask

   task automatic walk(input logic [63:0] va, input bit extra_start, input logic [63:0] va2,
                       output logic [63:0] pa, output logic [2:0] pm, output logic [1:0] ft);
      int n;
      @(negedge clk);
      rd_cnt = 0;
      start_i = 1'b1;
      vaddr_i = va;
      @(negedge clk);
      start_i = 1'b0;
      if (extra_start) begin
         start_i = 1'b1;
         vaddr_i = va2;
         @(negedge clk);
         start_i = 1'b0;
      end
      n = 0;
      while (!done_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(done_o, "R10 done seen", {63'h0, done_o}, 64'h1);
      pa = paddr_o;
      pm = {perm_w_o, perm_u_o, perm_nx_o};
      ft = fault_o;
      @(negedge clk);
      chk(!done_o && !busy_o, "R10 single pulse", {62'h0, done_o, busy_o}, 64'h0);
   endtask

   // common table set
   logic [63:0] tbl [5];
   logic [63:0] junk = 64'h4000_0000_0000_00E0;

   task automatic t_reset;
      chk(!done_o && !busy_o && !mem_req_valid_o, "R1 reset state",
          {61'h0, done_o, busy_o, mem_req_valid_o}, 64'h0);
   endtask

   task automatic t_basic;
      logic [63:0] va = 64'h0000_7F12_3456_789A;
      logic [63:0] fl [4];
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      for (int l = 0; l < 4; l++) fl[l] = 64'h7 | junk;
      build(va, tbl, fl);
      walk(va, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b00, "R5 fault none", {62'h0, ft}, 64'h0);
      chk(pa == (tbl[4] | 64'h89A), "R5 paddr", pa, tbl[4] | 64'h89A);
      chk(rd_cnt == 4, "R5 four reads", rd_cnt, 4);
      for (int l = 0; l < 4; l++)
         chk(rd_addr[l] == ent_addr(tbl[l], va, l), "R3 R4 entry address", rd_addr[l], ent_addr(tbl[l], va, l));
      chk(pm == 3'b110, "R7 all-permissive perms", {61'h0, pm}, 64'h6);
   endtask

   task automatic t_perm_mix;
      logic [63:0] va = 64'h0000_0000_001F_0ABC;
      logic [63:0] fl [4];
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      fl[0] = 64'h7; fl[1] = 64'h5; fl[2] = 64'h3; fl[3] = 64'h8000_0000_0000_0007;
      build(va, tbl, fl);
      walk(va, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b00, "R7 fault none", {62'h0, ft}, 64'h0);
      chk(pm == 3'b001, "R7 AND/OR perms", {61'h0, pm}, 64'h1);
      chk(pa == (tbl[4] | 64'hABC), "R5 paddr mix", pa, tbl[4] | 64'hABC);
   endtask

   task automatic t_kernel_half;
      logic [63:0] va = 64'hFFFF_8123_4567_8ABC;
      logic [63:0] fl [4];
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      for (int l = 0; l < 4; l++) fl[l] = 64'h3;
      build(va, tbl, fl);
      walk(va, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b00, "R2 upper-half canonical accepted", {62'h0, ft}, 64'h0);
      chk(pa == (tbl[4] | 64'hABC), "R5 paddr upper half", pa, tbl[4] | 64'hABC);
      chk(rd_addr[0] == ent_addr(tbl[0], va, 0), "R3 top index upper half", rd_addr[0], ent_addr(tbl[0], va, 0));
      chk(pm == 3'b100, "R7 supervisor perms", {61'h0, pm}, 64'h4);
   endtask

   task automatic t_noncanon;
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      walk(64'h0001_0000_0000_0000, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b01, "R2 fault code low half", {62'h0, ft}, 64'h1);
      chk(rd_cnt == 0, "R2 no read", rd_cnt, 0);
      chk(pa == 64'h0 && pm == 3'b000, "R2 zero result", pa | {61'h0, pm}, 64'h0);
      walk(64'hFFFF_0000_0000_1000, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b01, "R2 fault code high half", {62'h0, ft}, 64'h1);
      chk(rd_cnt == 0, "R2 no read high half", rd_cnt, 0);
   endtask

   task automatic t_notpresent;
      logic [63:0] va = 64'h0000_1234_5678_9000;
      logic [63:0] fl [4];
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      fl[0] = 64'h7; fl[1] = 64'h7; fl[2] = 64'h6; fl[3] = 64'h7;
      build(va, tbl, fl);
      walk(va, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b10, "R6 fault code level 2", {62'h0, ft}, 64'h2);
      chk(rd_cnt == 3, "R6 stops after third read", rd_cnt, 3);
      chk(pa == 64'h0 && pm == 3'b000, "R6 zero result", pa | {61'h0, pm}, 64'h0);
      fl[0] = 64'h6;
      build(va, tbl, fl);
      walk(va, 1'b0, 64'h0, pa, pm, ft);
      chk(ft == 2'b10, "R6 fault code top level", {62'h0, ft}, 64'h2);
      chk(rd_cnt == 1, "R6 stops after first read", rd_cnt, 1);
   endtask

   task automatic t_stall;
      logic [63:0] va = 64'h0000_0ABC_DEF0_1234;
      logic [63:0] fl [4];
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      for (int l = 0; l < 4; l++) fl[l] = 64'h7;
      build(va, tbl, fl);
      hold_err = 0;
      stall_mode = 1'b1;
      walk(va, 1'b0, 64'h0, pa, pm, ft);
      stall_mode = 1'b0;
      chk(hold_err == 0, "R8 request held under stall", hold_err, 0);
      chk(rd_cnt == 4, "R8 one read per level", rd_cnt, 4);
      chk(pa == (tbl[4] | 64'h234), "R8 paddr under stall", pa, tbl[4] | 64'h234);
      for (int l = 0; l < 4; l++)
         chk(rd_addr[l] == ent_addr(tbl[l], va, l), "R8 address under stall", rd_addr[l], ent_addr(tbl[l], va, l));
   endtask

   task automatic t_busy_start;
      logic [63:0] va = 64'h0000_0000_4000_0777;
      logic [63:0] fl [4];
      logic [63:0] pa; logic [2:0] pm; logic [1:0] ft;
      for (int l = 0; l < 4; l++) fl[l] = 64'h7;
      build(va, tbl, fl);
      walk(va, 1'b1, 64'h0002_0000_0000_0000, pa, pm, ft);
      chk(ft == 2'b00, "R9 start ignored keeps fault none", {62'h0, ft}, 64'h0);
      chk(pa == (tbl[4] | 64'h777), "R9 first walk result", pa, tbl[4] | 64'h777);
      chk(rd_cnt == 4, "R9 reads of first walk only", rd_cnt, 4);
   endtask

   initial begin
      tbl[0] = 64'hFFF0_0000_0010_0ABC;  // junk outside bits 51:12
      tbl[1] = 64'h0000_0000_0020_1000;
      tbl[2] = 64'h0000_0000_0030_2000;
      tbl[3] = 64'h0000_0000_0040_3000;
      tbl[4] = 64'h0000_000A_BCDE_F000;
      root_base_i = tbl[0];
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_perm_mix;
      t_kernel_half;
      t_noncanon;
      t_notpresent;
      t_stall;
      t_busy_start;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule